// File: doc/BRIEF.md
# Dual-Channel Encoder Position Plausibility Checker

This block watches two independent encoder interfaces that describe the same shaft. Each channel delivers a position word, a signed speed word, a sample strobe and a communication-error flag. At each control-cycle boundary, marked by a one-cycle tick, the block decides whether each channel produced a clean sample during the cycle. If both did, it compares them. The position difference is taken as the shortest distance around the single-turn circle. The speed difference is the absolute value of the signed difference. Each difference is tested against its own programmable limit.

Mismatches pass through a persistence filter. An up/down counter steps up on every violating comparison and steps down, never below zero, on every clean one. The fault flag asserts when the counter reaches a programmable limit, so one stray sample cannot trip it. The fault stays set until software clears it, and a clear is honoured only while no violation is present.

A primary position goes to the motion controller. It normally follows channel A. It moves to channel B when only B is healthy, and it freezes when neither channel is healthy. Both raw channels and a compact status word are also exposed for a safety processor.

Top module: `dual_enc_plausibility`

## Requirements
- R1: After reset is released, `pos_primary`, `status`, `fault` and all four raw channel outputs read zero.
- R2: When both channels are compared, status bit 5 (position mismatch) is set if the modular distance between the positions exceeds `pos_thr`. The modular distance is min(|A−B|, 2^POS_W − |A−B|), so a channel that wraps from full scale to zero does not register a mismatch. A distance equal to the threshold is not a mismatch.
- R3: When both channels are compared, status bit 4 (speed mismatch) is set if |A−B| of the two's-complement speeds exceeds `spd_thr`. Equality is not a mismatch.
- R4: At a tick, a channel counts as healthy if it strobed at least once since the previous tick, including the tick cycle itself, and raised no error in that span. Status bit 3 marks channel A unhealthy and bit 2 marks channel B unhealthy. Bit 6 (compared) is set only when both are healthy. When bit 6 is clear, bits 5 and 4 read zero.
- R5: The persistence count rises by one, saturating, on each compared tick with a mismatch. It falls by one, stopping at zero, on each compared tick without one. It holds on ticks without a comparison. `fault` sets on the tick at which the count reaches `persist_lim`.
- R6: With `persist_lim` above one, an isolated mismatch followed by a clean comparison leaves `fault` low.
- R7: When A is healthy, `pos_primary` takes A's position at the tick, with status bit 1 clear. When only B is healthy, it takes B's position and sets bit 1. When neither is healthy, it holds its value and sets bit 0 (frozen). Bits 1 and 0 are never both set.
- R8: `fault` is sticky. `fault_clr` clears it, and also zeroes the persistence count, only while no violation is present. The present violation is the current comparison on a tick cycle, and otherwise the last registered status bits 5 and 4. A fault being set in the same cycle wins over the clear.
- R9: Each raw output pair (`a_pos_o`/`a_spd_o`, `b_pos_o`/`b_spd_o`) shows the latest strobed sample of its channel from the cycle after the strobe, whether or not an error was flagged.
- R10: `pos_primary` and `status` change only on the clock edge that ends a tick cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_tick | input | 1 | Control-cycle boundary, one cycle wide |
| a_vld | input | 1 | Channel A sample strobe |
| a_err | input | 1 | Channel A communication error |
| a_pos | input | POS_W | Channel A position |
| a_spd | input | SPD_W | Channel A speed, two's complement |
| b_vld | input | 1 | Channel B sample strobe |
| b_err | input | 1 | Channel B communication error |
| b_pos | input | POS_W | Channel B position |
| b_spd | input | SPD_W | Channel B speed, two's complement |
| pos_thr | input | POS_W | Position mismatch threshold |
| spd_thr | input | SPD_W | Speed mismatch threshold (unsigned) |
| persist_lim | input | CNT_W | Persistence count that trips the fault |
| fault_clr | input | 1 | Request to clear the sticky fault |
| pos_primary | output | POS_W | Position for the motion controller |
| a_pos_o | output | POS_W | Latest channel A position |
| a_spd_o | output | SPD_W | Latest channel A speed |
| b_pos_o | output | POS_W | Latest channel B position |
| b_spd_o | output | SPD_W | Latest channel B speed |
| status | output | 7 | {compared, pos_mis, spd_mis, fail_a, fail_b, src_b, frozen}, bit 6 down to 0 |
| fault | output | 1 | Sticky plausibility fault |

## Verification
The delicate collision is a clear request arriving on the same tick that registers a comparison. A violating comparison must win over the clear and set the fault. A clean comparison must let the same clear through, even though the status registered before that edge still shows a violation. The bench provokes both cases on purpose, and also a clear against an older latched violation without a tick. It then judges the outcome from `fault` one cycle later and from the count that follows, observed through how many further mismatches it takes to trip. A second overlap, a strobe landing in the tick cycle itself, is exercised by every table vector.

// File: rtl/plaus_pkg.sv
package plaus_pkg;
  localparam int NCH    = 2;
  localparam int STAT_W = 7;

  typedef struct packed {
    logic compared;
    logic pos_mis;
    logic spd_mis;
    logic fail_a;
    logic fail_b;
    logic src_b;
    logic frozen;
  } plaus_stat_t;
endpackage

// File: rtl/plaus_chan_capture.sv
module plaus_chan_capture #(
  parameter int POS_W = 16,
  parameter int SPD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             vld,
  input  logic             err,
  input  logic [POS_W-1:0] pos,
  input  logic [SPD_W-1:0] spd,
  output logic [POS_W-1:0] pos_q,
  output logic [SPD_W-1:0] spd_q,
  output logic [POS_W-1:0] eff_pos,
  output logic [SPD_W-1:0] eff_spd,
  output logic             healthy
);
  logic seen_q, seen_d, errs_q, errs_d;
  logic [POS_W-1:0] pos_d;
  logic [SPD_W-1:0] spd_d;
  logic seen_eff, err_eff;

  // a strobe in the tick cycle belongs to the cycle being closed
  always_comb begin
    seen_eff = seen_q | vld;
    err_eff  = errs_q | err;
    healthy  = seen_eff & ~err_eff;
    eff_pos  = vld ? pos : pos_q;
    eff_spd  = vld ? spd : spd_q;
    pos_d    = eff_pos;
    spd_d    = eff_spd;
    seen_d   = tick ? 1'b0 : seen_eff;
    errs_d   = tick ? 1'b0 : err_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      spd_q  <= '0;
      seen_q <= 1'b0;
      errs_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      spd_q  <= spd_d;
      seen_q <= seen_d;
      errs_q <= errs_d;
    end
  end
endmodule

// File: rtl/plaus_diff.sv
module plaus_diff #(
  parameter int POS_W = 16,
  parameter int SPD_W = 12
) (
  input  logic [POS_W-1:0] pos_a,
  input  logic [POS_W-1:0] pos_b,
  input  logic [SPD_W-1:0] spd_a,
  input  logic [SPD_W-1:0] spd_b,
  input  logic [POS_W-1:0] pos_thr,
  input  logic [SPD_W-1:0] spd_thr,
  output logic             pos_mis,
  output logic             spd_mis
);
  localparam int SX_W = SPD_W + 1;
  localparam logic [POS_W-1:0] P_ONE = POS_W'(1);
  localparam logic [SX_W-1:0]  S_ONE = SX_W'(1);

  logic [POS_W-1:0] pdiff, pdist;
  logic [SX_W-1:0]  sdiff, sabs;

  always_comb begin
    // modular difference folded to the shorter arc
    pdiff   = pos_a - pos_b;
    pdist   = pdiff[POS_W-1] ? (~pdiff + P_ONE) : pdiff;
    sdiff   = {spd_a[SPD_W-1], spd_a} - {spd_b[SPD_W-1], spd_b};
    sabs    = sdiff[SX_W-1] ? (~sdiff + S_ONE) : sdiff;
    pos_mis = pdist > pos_thr;
    spd_mis = sabs > {1'b0, spd_thr};
  end
endmodule

// File: rtl/plaus_persist.sv
module plaus_persist #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             eval,
  input  logic             mis,
  input  logic             mis_last,
  input  logic             clr,
  input  logic [CNT_W-1:0] lim,
  output logic             fault
);
  localparam logic [CNT_W-1:0] C_MAX = '1;
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic fault_q, fault_d;
  logic mis_now, set_f, clr_ok;

  always_comb begin
    cnt_inc = (cnt_q == C_MAX) ? cnt_q : cnt_q + C_ONE;
    mis_now = tick ? (eval & mis) : mis_last;
    set_f   = eval & mis & (cnt_inc >= lim);
    clr_ok  = clr & ~mis_now;
    cnt_d   = cnt_q;
    if (clr_ok)
      cnt_d = '0;
    else if (eval)
      cnt_d = mis ? cnt_inc : ((cnt_q == '0) ? cnt_q : cnt_q - C_ONE);
    fault_d = fault_q;
    if (set_f)
      fault_d = 1'b1;
    else if (clr_ok)
      fault_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  assign fault = fault_q;
endmodule

// File: rtl/dual_enc_plausibility.sv
module dual_enc_plausibility
  import plaus_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int SPD_W = 12,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cycle_tick,
  input  logic               a_vld,
  input  logic               a_err,
  input  logic [POS_W-1:0]   a_pos,
  input  logic [SPD_W-1:0]   a_spd,
  input  logic               b_vld,
  input  logic               b_err,
  input  logic [POS_W-1:0]   b_pos,
  input  logic [SPD_W-1:0]   b_spd,
  input  logic [POS_W-1:0]   pos_thr,
  input  logic [SPD_W-1:0]   spd_thr,
  input  logic [CNT_W-1:0]   persist_lim,
  input  logic               fault_clr,
  output logic [POS_W-1:0]   pos_primary,
  output logic [POS_W-1:0]   a_pos_o,
  output logic [SPD_W-1:0]   a_spd_o,
  output logic [POS_W-1:0]   b_pos_o,
  output logic [SPD_W-1:0]   b_spd_o,
  output logic [STAT_W-1:0]  status,
  output logic               fault
);
  logic             in_vld  [NCH];
  logic             in_err  [NCH];
  logic [POS_W-1:0] in_pos  [NCH];
  logic [SPD_W-1:0] in_spd  [NCH];
  logic [POS_W-1:0] raw_pos [NCH];
  logic [SPD_W-1:0] raw_spd [NCH];
  logic [POS_W-1:0] eff_pos [NCH];
  logic [SPD_W-1:0] eff_spd [NCH];
  logic             ok      [NCH];

  assign in_vld[0] = a_vld;  assign in_vld[1] = b_vld;
  assign in_err[0] = a_err;  assign in_err[1] = b_err;
  assign in_pos[0] = a_pos;  assign in_pos[1] = b_pos;
  assign in_spd[0] = a_spd;  assign in_spd[1] = b_spd;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    plaus_chan_capture #(.POS_W(POS_W), .SPD_W(SPD_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (cycle_tick),
      .vld     (in_vld[ch]),
      .err     (in_err[ch]),
      .pos     (in_pos[ch]),
      .spd     (in_spd[ch]),
      .pos_q   (raw_pos[ch]),
      .spd_q   (raw_spd[ch]),
      .eff_pos (eff_pos[ch]),
      .eff_spd (eff_spd[ch]),
      .healthy (ok[ch])
    );
  end

  logic pos_mis, spd_mis, both_ok, eval;

  plaus_diff #(.POS_W(POS_W), .SPD_W(SPD_W)) u_diff (
    .pos_a   (eff_pos[0]),
    .pos_b   (eff_pos[1]),
    .spd_a   (eff_spd[0]),
    .spd_b   (eff_spd[1]),
    .pos_thr (pos_thr),
    .spd_thr (spd_thr),
    .pos_mis (pos_mis),
    .spd_mis (spd_mis)
  );

  plaus_stat_t      stat_q, stat_d;
  logic [POS_W-1:0] prim_q, prim_d;

  assign both_ok = ok[0] & ok[1];
  assign eval    = cycle_tick & both_ok;

  plaus_persist #(.CNT_W(CNT_W)) u_persist (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (cycle_tick),
    .eval     (eval),
    .mis      (pos_mis | spd_mis),
    .mis_last (stat_q.pos_mis | stat_q.spd_mis),
    .clr      (fault_clr),
    .lim      (persist_lim),
    .fault    (fault)
  );

  always_comb begin
    stat_d = stat_q;
    prim_d = prim_q;
    if (cycle_tick) begin
      stat_d          = '0;
      stat_d.compared = both_ok;
      stat_d.pos_mis  = both_ok & pos_mis;
      stat_d.spd_mis  = both_ok & spd_mis;
      stat_d.fail_a   = ~ok[0];
      stat_d.fail_b   = ~ok[1];
      if (ok[0]) begin
        prim_d = eff_pos[0];
      end else if (ok[1]) begin
        prim_d       = eff_pos[1];
        stat_d.src_b = 1'b1;
      end else begin
        stat_d.frozen = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      prim_q <= '0;
    end else if (cycle_tick) begin
      stat_q <= stat_d;
      prim_q <= prim_d;
    end
  end

  assign pos_primary = prim_q;
  assign status      = stat_q;
  assign a_pos_o     = raw_pos[0];
  assign a_spd_o     = raw_spd[0];
  assign b_pos_o     = raw_pos[1];
  assign b_spd_o     = raw_spd[1];
endmodule

// File: rtl/plaus_checker.sv
module plaus_checker #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cycle_tick,
  input logic             fault_clr,
  input logic [POS_W-1:0] pos_primary,
  input logic [6:0]       status,
  input logic             fault
);
  a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_tick |=> ($stable(pos_primary) && $stable(status)));

  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> $past(fault_clr));

  a_r5_fault_needs_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (status[6] && (status[5] || status[4])));

  a_r4_compare_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> (!status[3] && !status[2]));

  a_r4_no_mismatch_uncompared: assert property (@(posedge clk) disable iff (!rst_n)
    !status[6] |-> (!status[5] && !status[4]));

  a_r7_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cycle_tick) && status[0]) |-> $stable(pos_primary));

  a_r7_source_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status[1], status[0]}));

  a_r7_b_source_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> (status[3] && !status[2]));
endmodule

bind dual_enc_plausibility plaus_checker #(.POS_W(POS_W)) u_plaus_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cycle_tick  (cycle_tick),
  .fault_clr   (fault_clr),
  .pos_primary (pos_primary),
  .status      (status),
  .fault       (fault)
);

// File: tb/dual_enc_plausibility_bench.sv
module dual_enc_plausibility_bench;
  localparam int CLK_P = 10;
  localparam int PW = 16;
  localparam int SW = 12;
  localparam int CW = 4;
  localparam int NV = 14;

  typedef struct packed {
    logic          a_vld;
    logic          a_err;
    logic [PW-1:0] a_pos;
    logic [SW-1:0] a_spd;
    logic          b_vld;
    logic          b_err;
    logic [PW-1:0] b_pos;
    logic [SW-1:0] b_spd;
    logic [6:0]    e_stat;
    logic [PW-1:0] e_pos;
    logic          e_fault;
  } vec_t;

  // thresholds: position 8, speed 20, persistence limit 3
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,16'd100,  12'd10,   1'b1,1'b0,16'd105,12'd12, 7'h40,16'd100,  1'b0}, // R4 R7 clean
    '{1'b1,1'b0,16'd65534,12'd0,    1'b1,1'b0,16'd3,  12'd0,  7'h40,16'd65534,1'b0}, // R2 wrap
    '{1'b1,1'b0,16'd200,  12'd0,    1'b1,1'b0,16'd208,12'd0,  7'h40,16'd200,  1'b0}, // R2 equal thr
    '{1'b1,1'b0,16'd200,  12'd0,    1'b1,1'b0,16'd209,12'd0,  7'h60,16'd200,  1'b0}, // R2 R6 mismatch
    '{1'b1,1'b0,16'd300,  12'd10,   1'b1,1'b0,16'd300,12'd10, 7'h40,16'd300,  1'b0}, // R6 clean
    '{1'b1,1'b0,16'd300,  12'hFF1,  1'b1,1'b0,16'd300,12'd6,  7'h50,16'd300,  1'b0}, // R3 -15 vs 6
    '{1'b1,1'b0,16'd300,  12'hFF1,  1'b1,1'b0,16'd300,12'd5,  7'h40,16'd300,  1'b0}, // R3 equal thr
    '{1'b1,1'b1,16'd999,  12'd0,    1'b1,1'b0,16'd400,12'd0,  7'h0A,16'd400,  1'b0}, // R4 R7 A error
    '{1'b1,1'b0,16'd500,  12'd0,    1'b0,1'b0,16'd0,  12'd0,  7'h04,16'd500,  1'b0}, // R4 R7 B missing
    '{1'b0,1'b0,16'd0,    12'd0,    1'b0,1'b0,16'd0,  12'd0,  7'h0D,16'd500,  1'b0}, // R7 frozen
    '{1'b1,1'b0,16'd0,    12'd0,    1'b1,1'b0,16'd100,12'd0,  7'h60,16'd0,    1'b0}, // R5 cnt 1
    '{1'b1,1'b0,16'd0,    12'd0,    1'b1,1'b0,16'd100,12'd0,  7'h60,16'd0,    1'b0}, // R5 cnt 2
    '{1'b1,1'b0,16'd0,    12'd0,    1'b1,1'b0,16'd100,12'd0,  7'h60,16'd0,    1'b1}, // R5 trip
    '{1'b1,1'b0,16'd0,    12'd0,    1'b1,1'b0,16'd3,  12'd0,  7'h40,16'd0,    1'b1}  // R8 sticky
  };

  logic clk, rst_n, cycle_tick, fault_clr;
  logic a_vld, a_err, b_vld, b_err;
  logic [PW-1:0] a_pos, b_pos, pos_thr, pos_primary, a_pos_o, b_pos_o;
  logic [SW-1:0] a_spd, b_spd, spd_thr, a_spd_o, b_spd_o;
  logic [CW-1:0] persist_lim;
  logic [6:0]    status;
  logic          fault;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  dual_enc_plausibility #(.POS_W(PW), .SPD_W(SW), .CNT_W(CW)) u_dual_enc_plausibility (
    .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick),
    .a_vld(a_vld), .a_err(a_err), .a_pos(a_pos), .a_spd(a_spd),
    .b_vld(b_vld), .b_err(b_err), .b_pos(b_pos), .b_spd(b_spd),
    .pos_thr(pos_thr), .spd_thr(spd_thr), .persist_lim(persist_lim),
    .fault_clr(fault_clr), .pos_primary(pos_primary),
    .a_pos_o(a_pos_o), .a_spd_o(a_spd_o), .b_pos_o(b_pos_o), .b_spd_o(b_spd_o),
    .status(status), .fault(fault)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic idle();
    cycle_tick = 0; fault_clr = 0;
    a_vld = 0; a_err = 0; a_pos = '0; a_spd = '0;
    b_vld = 0; b_err = 0; b_pos = '0; b_spd = '0;
  endtask

  // one tick cycle with both channels strobing in it
  task automatic pair_tick(input logic [PW-1:0] pa, input logic [PW-1:0] pb, input logic clr);
    @(negedge clk);
    cycle_tick = 1; fault_clr = clr;
    a_vld = 1; a_pos = pa; b_vld = 1; b_pos = pb;
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    pos_thr = 16'd8; spd_thr = 12'd20; persist_lim = 4'd3;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 pos_primary", 32'(pos_primary), 0);
    check("R1 status", 32'(status), 0);
    check("R1 fault", 32'(fault), 0);
    check("R1 a_pos_o", 32'(a_pos_o), 0);
    check("R1 b_spd_o", 32'(b_spd_o), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cycle_tick = 1;
      a_vld = VECS[i].a_vld; a_err = VECS[i].a_err; a_pos = VECS[i].a_pos; a_spd = VECS[i].a_spd;
      b_vld = VECS[i].b_vld; b_err = VECS[i].b_err; b_pos = VECS[i].b_pos; b_spd = VECS[i].b_spd;
      @(negedge clk);
      idle();
      check($sformatf("R2/R3/R4/R7 table %0d status", i), 32'(status), 32'(VECS[i].e_stat));
      check($sformatf("R7 table %0d pos_primary", i), 32'(pos_primary), 32'(VECS[i].e_pos));
      check($sformatf("R5/R6 table %0d fault", i), 32'(fault), 32'(VECS[i].e_fault));
    end

    // R9 raw sample visible without a tick; R10 primary and status untouched
    @(negedge clk);
    a_vld = 1; a_pos = 16'd777; a_spd = 12'd33;
    @(negedge clk);
    idle();
    check("R9 a_pos_o", 32'(a_pos_o), 32'd777);
    check("R9 a_spd_o", 32'(a_spd_o), 32'd33);
    check("R10 pos_primary held", 32'(pos_primary), 0);
    check("R10 status held", 32'(status), 32'h40);

    // R4 sample earlier in the cycle counts; B missing
    @(negedge clk);
    cycle_tick = 1;
    @(negedge clk);
    idle();
    check("R4 early sample status", 32'(status), 32'h04);
    check("R7 early sample pos", 32'(pos_primary), 32'd777);

    // R8 clear with no violation present
    @(negedge clk);
    fault_clr = 1;
    @(negedge clk);
    idle();
    check("R8 clear accepted", 32'(fault), 0);

    // R8 counter zeroed by the clear: two mismatches do not trip
    pair_tick(16'd0, 16'd100, 1'b0);
    check("R8 count zeroed 1", 32'(fault), 0);
    pair_tick(16'd0, 16'd100, 1'b0);
    check("R8 count zeroed 2", 32'(fault), 0);
    // R8 mismatch and clear in one tick cycle: set wins
    pair_tick(16'd0, 16'd100, 1'b1);
    check("R8 set beats clear", 32'(fault), 1);
    // R8 clear against a latched violation is ignored
    @(negedge clk);
    fault_clr = 1;
    @(negedge clk);
    idle();
    check("R8 clear blocked", 32'(fault), 1);
    // R8 clean comparison in the same cycle as clear lets it through
    pair_tick(16'd50, 16'd52, 1'b1);
    check("R8 clear on clean tick", 32'(fault), 0);
    check("R8 clean tick status", 32'(status), 32'h40);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule